// File: doc/BRIEF.md
# Flash Page Load Buffer with Inactivity Timeout

This block is the device-side page collection stage of a byte-wide flash. A host issues byte-load strobes, each with a 17-bit byte address and an 8-bit value. The low seven address bits select a slot in a 128-byte page buffer. The upper ten bits name the page. Loads may arrive in any order and may repeat a slot. The block does not wait for an explicit commit. An inactivity timer restarts on every accepted load, and programming begins once the timer expires.

When programming begins, the block raises a busy flag. It then streams the whole page to the array-write stage, one byte per cycle, in ascending slot order. Each byte goes out with its full array address, formed from the captured page number and the slot index. A slot that was never loaded is sent as the erased value FFh. Busy stays high for a fixed programming time, and nothing can cut that time short. Load strobes that arrive while busy is high do not touch the buffer, and each one raises a reject pulse.

The controller has three states. `ST_IDLE` waits for the first load of a page. `ST_LOAD` collects further bytes while the timer runs. `ST_PROG` streams the page and then waits out the programming time. There are three transitions. *first_load* goes from `ST_IDLE` to `ST_LOAD`: it clears the written-mask and stores the byte. *load_timeout* goes from `ST_LOAD` to `ST_PROG` when the timer expires. *prog_done* goes from `ST_PROG` to `ST_IDLE` at the end of the programming time.

Top module: `pgload_top`

## Requirements
- R1: After reset, `busy`, `wr_en` and `ld_reject` are all 0.
- R2: An accepted load stores `ld_data` in slot `ld_addr[6:0]`. During programming, that slot is written with that value.
- R3: A slot that received no load in the current page is written as 8'hFF.
- R4: A later load to a slot replaces the value from an earlier load to the same slot.
- R5: The page number is `ld_addr[16:7]` of the most recent accepted load. Every write uses `wr_addr = {page number, slot}`.
- R6: If each load follows the previous one by at most TIMEOUT_CYC clock cycles, `busy` stays 0, however many loads are made.
- R7: When TIMEOUT_CYC cycles pass with no load after the last accepted one, `busy` rises in that cycle. `wr_en` is high for 128 consecutive cycles from then on, with slots 0, 1, …, 127 in order.
- R8: `busy` stays high for exactly PROG_CYC cycles and then falls. No input shortens it.
- R9: A load strobe while `busy` is 1 is ignored. `ld_reject` is 1 in that same cycle.
- R10: A new page starts empty. Slots loaded in an earlier page, or strobed while busy, are written as 8'hFF unless they are loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Byte-load strobe, one cycle per byte |
| ld_addr | input | 17 | Byte address: page number in [16:7], slot in [6:0] |
| ld_data | input | 8 | Byte value to load |
| busy | output | 1 | Internal programming cycle in progress |
| ld_reject | output | 1 | Strobe arrived while busy and was dropped |
| wr_en | output | 1 | Array write strobe, one byte per cycle |
| wr_addr | output | 17 | Array byte address of the current write |
| wr_data | output | 8 | Byte value of the current write |

## Verification
The hardest case to reach is a load at the very last cycle of the timeout window, where a load and the timer expiry land on the same edge. The stimulus reaches it by releasing a load and then waiting exactly TIMEOUT_CYC−1 falling edges before driving the next strobe. It repeats this pattern over several loads and checks that busy stays low. The other hard case is a strobe in the middle of programming. The stimulus lets a page time out, drives loads while the array stream is still running, and then opens a fresh page. This shows that neither the rejected byte nor the old page's contents survive.

// File: rtl/pgload_pkg.sv
package pgload_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pg_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pgload_buf.sv
module pgload_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_mask,
    input  logic              we,
    input  logic [OFF_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled_q;

    // Data slots carry no reset; validity lives in the written-mask.
    genvar gi;
    generate
        for (gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (we && (waddr == OFF_W'(gi))) begin
                    slot_q[gi] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled_q <= '0;
        end else begin
            if (clr_mask) begin
                filled_q <= '0;
            end
            if (we) begin
                filled_q[waddr] <= 1'b1;
            end
        end
    end

    always_comb begin
        if (filled_q[raddr]) begin
            rdata = slot_q[raddr];
        end else begin
            rdata = {DATA_W{1'b1}};
        end
    end

    // R10: a cleared page exposes only the slot being written in that cycle
    a_r10_mask_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_mask) && $past(we)) |-> ($countones(filled_q) == 1))
        else $error("a_r10_mask_fresh");

endmodule

// File: rtl/pgload_timer.sv
module pgload_timer #(
    parameter int TIMEOUT_CYC = 20000,
    localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    logic [CNT_W-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (restart || !run) begin
            idle_q <= '0;
        end else if (idle_q != CNT_W'(TIMEOUT_CYC - 1)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign expire = run && !restart && (idle_q == CNT_W'(TIMEOUT_CYC - 1));

    // R6: idle count never runs past the window
    a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q < CNT_W'(TIMEOUT_CYC))
        else $error("a_r6_timer_bound");

    // R6: a load always restarts the window
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> (idle_q == '0))
        else $error("a_r6_restart");

endmodule

// File: rtl/pgload_prog.sv
module pgload_prog #(
    parameter int PAGE_BYTES = 128,
    parameter int PROG_CYC   = 500000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PROG_LEN  = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES,
    localparam int CNT_W     = $clog2(PROG_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    output logic             stream,
    output logic [OFF_W-1:0] slot,
    output logic             done
);
    logic [CNT_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!active || done) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign stream = active && (tick_q < CNT_W'(PAGE_BYTES));
    assign slot   = tick_q[OFF_W-1:0];
    assign done   = active && (tick_q == CNT_W'(PROG_LEN - 1));

    // R8: the tick never passes the programming length
    a_r8_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q < CNT_W'(PROG_LEN))
        else $error("a_r8_tick_bound");

    // R7: consecutive streamed slots ascend by one
    a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stream && $past(stream)) |-> (slot == $past(slot) + 1'b1))
        else $error("a_r7_slot_step");

endmodule

// File: rtl/pgload_top.sv
module pgload_top #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 128,
    parameter int TIMEOUT_CYC = 20000,
    parameter int PROG_CYC    = 500000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              busy,
    output logic              ld_reject,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    import pgload_pkg::*;

    pg_state_e        state_q, state_d;
    logic [PG_W-1:0]  page_q;
    logic             accept, first_load, tmr_expire;
    logic             prog_stream, prog_done;
    logic [OFF_W-1:0] prog_slot;
    logic [DATA_W-1:0] buf_rd;

    assign accept     = ld_valid && (state_q != ST_PROG);
    assign first_load = ld_valid && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ld_valid)   state_d = ST_LOAD;
            ST_LOAD: if (tmr_expire) state_d = ST_PROG;
            ST_PROG: if (prog_done)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Page number follows the last accepted load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (accept) begin
            page_q <= ld_addr[ADDR_W-1:OFF_W];
        end
    end

    pgload_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (first_load),
        .we       (accept),
        .waddr    (ld_addr[OFF_W-1:0]),
        .wdata    (ld_data),
        .raddr    (prog_slot),
        .rdata    (buf_rd)
    );

    pgload_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_LOAD),
        .restart (accept),
        .expire  (tmr_expire)
    );

    pgload_prog #(
        .PAGE_BYTES (PAGE_BYTES),
        .PROG_CYC   (PROG_CYC)
    ) u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_PROG),
        .stream (prog_stream),
        .slot   (prog_slot),
        .done   (prog_done)
    );

    // Outputs
    always_comb begin
        busy      = 1'b0;
        ld_reject = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = {page_q, prog_slot};
        wr_data   = buf_rd;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                busy = 1'b0;
            end
            ST_PROG: begin
                busy      = 1'b1;
                ld_reject = ld_valid;
                wr_en     = prog_stream;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R1 / R9: a reject only happens while busy
    a_r9_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ld_reject |-> busy)
        else $error("a_r9_reject_busy");

    // R7: array writes only while busy
    a_r7_wr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy)
        else $error("a_r7_wr_in_busy");

    // R7: busy rises only after the timer expired in the previous cycle
    a_r7_start_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tmr_expire))
        else $error("a_r7_start_on_expire");

    // R7: the stream opens with slot 0 in the first busy cycle
    a_r7_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wr_en && (wr_addr[OFF_W-1:0] == '0)))
        else $error("a_r7_first_slot");

    // R5 / R9: page number is frozen while busy
    a_r5_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wr_addr[ADDR_W-1:OFF_W]))
        else $error("a_r5_page_frozen");

    // R8: busy falls only when the programming time has run out
    a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_done))
        else $error("a_r8_no_abort");

endmodule

// File: tb/sim_pgload_top.sv
`timescale 1ns/1ps
module sim_pgload_top;
    localparam int TO   = 16;
    localparam int PC   = 200;
    localparam int PB   = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [16:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        busy, ld_reject, wr_en;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pgload_top #(
        .TIMEOUT_CYC (TO),
        .PROG_CYC    (PC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .ld_valid (ld_valid), .ld_addr (ld_addr),
        .ld_data (ld_data), .busy (busy), .ld_reject (ld_reject),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    // Behavioural array-write capture for one page
    logic [7:0] cap [PB];
    logic [9:0] cap_page;
    int seg_wr = 0, seg_busy = 0, order_err = 0, page_err = 0;
    logic prev_busy = 1'b0;

    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            seg_wr = 0; seg_busy = 0; order_err = 0; page_err = 0;
            cap_page = wr_addr[16:7];
        end
        if (busy) seg_busy = seg_busy + 1;
        if (wr_en) begin
            if (int'(wr_addr[6:0]) != seg_wr || seg_busy != seg_wr + 1) order_err = order_err + 1;
            if (wr_addr[16:7] != cap_page) page_err = page_err + 1;
            cap[wr_addr[6:0]] = wr_data;
            seg_wr = seg_wr + 1;
        end
        prev_busy = busy;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge; returns at the next falling edge
    task automatic load(input logic [16:0] a, input logic [7:0] d);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // After the last load's release, confirm the exact start edge
    task automatic expect_start(input string tag);
        repeat (TO - 1) @(negedge clk);
        check(busy == 1'b0, {tag, " R7 busy before timeout"}, busy, 0);
        @(negedge clk);
        check(busy == 1'b1, {tag, " R7 busy at timeout"}, busy, 1);
        check(wr_en && wr_addr[6:0] == 7'd0, {tag, " R7 first slot"}, wr_addr[6:0], 0);
    endtask

    task automatic finish_prog(input string tag);
        while (busy) @(negedge clk);
        check(seg_busy == PC, {tag, " R8 busy length"}, seg_busy, PC);
        check(seg_wr == PB && order_err == 0, {tag, " R7 stream order"}, seg_wr, PB);
        check(page_err == 0, {tag, " R5 constant page"}, page_err, 0);
    endtask

    task automatic t_reset;
        check(busy == 0 && wr_en == 0 && ld_reject == 0, "R1 reset outputs",
              {busy, wr_en, ld_reject}, 0);
    endtask

    task automatic t_sparse;
        load({10'h155, 7'd3}, 8'h3C);
        repeat (2) @(negedge clk);
        load({10'h155, 7'd127}, 8'h81);
        expect_start("sparse");
        finish_prog("sparse");
        check(cap[3] == 8'h3C, "R2 slot 3", cap[3], 8'h3C);
        check(cap[127] == 8'h81, "R2 slot 127", cap[127], 8'h81);
        check(cap[0] == 8'hFF && cap[64] == 8'hFF, "R3 unloaded FF", cap[64], 8'hFF);
        check(cap_page == 10'h155, "R5 page number", cap_page, 10'h155);
    endtask

    task automatic t_overwrite;
        load({10'h001, 7'd10}, 8'h11);
        load({10'h001, 7'd10}, 8'h22);
        load({10'h2A3, 7'd11}, 8'h33);
        expect_start("ovw");
        finish_prog("ovw");
        check(cap[10] == 8'h22, "R4 overwrite", cap[10], 8'h22);
        check(cap_page == 10'h2A3, "R5 last load page", cap_page, 10'h2A3);
        check(cap[3] == 8'hFF && cap[127] == 8'hFF, "R10 old page gone", cap[127], 8'hFF);
    endtask

    task automatic t_gap;
        int hold_bad = 0;
        for (int i = 0; i < 8; i++) begin
            load({10'h0F0, 7'(i)}, 8'(8'hA0 + i));
            repeat (TO - 1) begin
                @(negedge clk);
                if (busy) hold_bad++;
            end
        end
        check(hold_bad == 0, "R6 max gap keeps load open", hold_bad, 0);
        @(negedge clk);
        check(busy == 1'b1, "R7 start after max gap run", busy, 1);
        finish_prog("gap");
        check(cap[0] == 8'hA0 && cap[7] == 8'hA7, "R6 all gap bytes kept", cap[7], 8'hA7);
    endtask

    task automatic t_reject;
        load({10'h050, 7'd5}, 8'h55);
        repeat (TO + 3) @(negedge clk);
        ld_valid = 1'b1; ld_addr = {10'h050, 7'd6}; ld_data = 8'h66;
        #1;
        check(ld_reject == 1'b1, "R9 reject pulse", ld_reject, 1);
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
        check(ld_reject == 1'b0, "R9 reject one cycle", ld_reject, 0);
        finish_prog("rej");
        check(cap[6] == 8'hFF && cap[5] == 8'h55, "R9 busy strobe ignored", cap[6], 8'hFF);
        load({10'h051, 7'd9}, 8'h99);
        expect_start("fresh");
        finish_prog("fresh");
        check(cap[5] == 8'hFF && cap[6] == 8'hFF && cap[9] == 8'h99,
              "R10 fresh page", cap[5], 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sparse();
        t_overwrite();
        t_gap();
        t_reject();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule